// File: doc/BRIEF.md
# Four-Lane Receive Pattern Verifier

This block checks recovered serial data on four independent receive lanes. Each lane delivers one parallel word of recovered bits per clock. Each lane holds its own configuration, copied from a shared set of control inputs while that lane's load strobe is high. The configuration chooses what the lane expects: a pseudo-random sequence of one of six lengths, an alternating clock pattern, or a repeating custom pattern of 16 or 20 bits. A further group of codes runs only the sync pulse generator and does no checking.

A checking lane starts in training. Its predictor builds its history from the received bits, or hunts the phase of the custom pattern. Once enough consecutive bits have matched the prediction, the lane locks. From then on the predictor runs on its own expected bits, so each corrupted bit counts exactly once. Errors found after lock go into a saturating 12-bit counter per lane. They also raise a live interrupt and a sticky flag that software clears by writing a one. A per-lane sync pulse marks each full period of the expected sequence.

Top module: `prbs_verifier`

## Requirements
- R1: While `load_i[l]` is high, lane l copies `mode_i`, `len_i`, `cpat_i` and `cpat_long_i` on every clock and restarts its checker. When the strobe is low, the lane keeps the values it holds, and changes on the shared inputs have no effect on it.
- R2: Select codes in `mode_i` are:
  - 3'b000: lane disabled; it does no checking and no counting, and its training, sync, interrupt and mismatch outputs stay 0.
  - 3'b001: pseudo-random sequence.
  - 3'b010: clock pattern. The expected bit is the inverse of the previous bit, so 1 is expected first after a restart.
  - 3'b011: custom pattern.
  - 3'b1xx: sync-only mode, which does no checking and no training.
- R3: `len_i` picks the sequence polynomial, with the newest bit first:
  - 3'b000: x^7+x^6+1
  - 3'b001: x^11+x^9+1
  - 3'b010: x^23+x^18+1
  - 3'b011: x^31+x^28+1
  - 3'b10x: x^15+x^14+1
  - 3'b11x: x^20+x^3+1

  The predicted bit is the XOR of the received (or expected) bits that many positions back.
- R4: In custom mode the lane expects `cpat_i[19:0]` when `cpat_long_i`=1, and `cpat_i[15:0]` otherwise, sent most significant bit first. While training, a mismatching bit makes the phase skip one extra position.
- R5: Within each word, bit WORD_W-1 is the first in time. A checking lane locks after LOCK_RUN consecutive correctly predicted bits. `training_o` is high while the lane's latched select code is 001, 010 or 011 and the lane is not locked.
- R6: Each mismatching bit after lock adds one to that lane's 12-bit error count. The count stops at 0xFFF, and bits seen during training are not counted.
- R7: A rising edge on `cnt_clr_i` clears all four counts on that clock, and the clear wins over any increment in the same clock. Holding `cnt_clr_i` high does not clear the counts again.
- R8: In the clock after a word, `irq_o[l]` is high if that word held an error that was counted. `mismatch_o[l]` is high if any bit of that word mismatched, whether the lane was training or locked.
- R9: `irq_flag_o[l]` is set by the same event that raises `irq_o[l]`, and is cleared by `flag_clr_i[l]`=1. A set in the same clock wins over the clear.
- R10: `sync_o[l]` pulses for one clock after each word that takes the lane's bit count since load past a multiple of the period. The period is 2^n-1 for the sequence and sync-only modes, 16 or 20 for custom mode, and there is no pulse in clock or disabled mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | N_LANES*WORD_W | Recovered word per lane, lane l at [l*WORD_W +: WORD_W] |
| load_i | input | N_LANES | Per-lane configuration load strobe |
| mode_i | input | 3 | Select code |
| len_i | input | 3 | Sequence length code |
| cpat_i | input | 20 | Custom pattern |
| cpat_long_i | input | 1 | 1 = use all 20 custom bits |
| cnt_clr_i | input | 1 | Counter clear, acts on rising edge |
| flag_clr_i | input | N_LANES | Write-one clear of latched flags |
| err_cnt_o | output | N_LANES*CNT_W | Saturating error counts |
| irq_o | output | N_LANES | Live test interrupt |
| irq_flag_o | output | N_LANES | Latched test interrupt |
| mismatch_o | output | N_LANES | Mismatch seen in last word |
| training_o | output | N_LANES | Lane searching for lock |
| sync_o | output | N_LANES | Pattern period marker |

## Verification
Two pairs of functions can act in the same clock. A counted error can arrive on the clock where the clear control rises, and a new error can arrive on the clock where a flag is cleared. The bench flips a bit in the word already on the inputs at the moment it raises the clear or the flag-clear strobe. It then expects a zero count in the first case and a flag that stays set in the second. A clock later it checks that a clear held high lets counting resume, and that a lone flag clear takes effect.

// File: rtl/pv_pkg.sv
package pv_pkg;
  localparam logic [2:0] SEL_OFF  = 3'b000;
  localparam logic [2:0] SEL_PRBS = 3'b001;
  localparam logic [2:0] SEL_CLK  = 3'b010;
  localparam logic [2:0] SEL_CUST = 3'b011;

  typedef struct packed {
    logic [2:0]  sel;
    logic [2:0]  len;
    logic [19:0] pat;
    logic        pat_long;
  } lane_cfg_t;

  function automatic logic [4:0] prbs_order(input logic [2:0] len);
    casez (len)
      3'b000:  return 5'd7;
      3'b001:  return 5'd11;
      3'b010:  return 5'd23;
      3'b011:  return 5'd31;
      3'b10?:  return 5'd15;
      default: return 5'd20;
    endcase
  endfunction

  function automatic logic [4:0] prbs_tap(input logic [2:0] len);
    casez (len)
      3'b000:  return 5'd6;
      3'b001:  return 5'd9;
      3'b010:  return 5'd18;
      3'b011:  return 5'd28;
      3'b10?:  return 5'd14;
      default: return 5'd3;
    endcase
  endfunction
endpackage

// File: rtl/pv_err_ctr.sv
module pv_err_ctr #(
  parameter int CNT_W = 12,
  parameter int INC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};
  logic [CNT_W:0] sum;

  assign sum = {1'b0, cnt_o} + (CNT_W+1)'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (clr_i)   cnt_o <= '0;
    else if (en_i)    cnt_o <= sum[CNT_W] ? MAX : sum[CNT_W-1:0];
  end
endmodule

// File: rtl/pv_sync_gen.sv
module pv_sync_gen #(
  parameter int WORD_W = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        hold_i,
  input  logic [31:0] per_i,   // 0 = no pulses; otherwise >= WORD_W
  output logic        sync_o
);
  logic [31:0] pos_q;
  logic [32:0] sum;

  assign sum = {1'b0, pos_q} + 33'(WORD_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      sync_o <= 1'b0;
    end else if (hold_i || per_i == '0) begin
      pos_q  <= '0;
      sync_o <= 1'b0;
    end else if (sum >= {1'b0, per_i}) begin
      pos_q  <= 32'(sum - {1'b0, per_i});
      sync_o <= 1'b1;
    end else begin
      pos_q  <= sum[31:0];
      sync_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pv_lane.sv
module pv_lane
  import pv_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int CNT_W    = 12,
  parameter int LOCK_RUN = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] data_i,
  input  logic              load_i,
  input  lane_cfg_t         cfg_i,
  input  logic              cnt_clr_i,
  input  logic              flag_clr_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              irq_o,
  output logic              flag_o,
  output logic              mis_o,
  output logic              train_o,
  output logic              sync_o
);
  localparam int EW    = $clog2(WORD_W + 1);
  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(LOCK_RUN);

  lane_cfg_t        cfg_q;
  logic [30:0]      s_q, s_n;
  logic             lock_q, lock_n;
  logic [RUN_W-1:0] run_q, run_n;
  logic [4:0]       ph_q, ph_n;
  logic [EW-1:0]    errs;
  logic             mis_n, chk;
  logic             b, e, ok, nb;
  logic [4:0]       tn, tm, plen, step;
  logic [31:0]      per;

  assign chk  = (cfg_q.sel != SEL_OFF) && !cfg_q.sel[2];
  assign tn   = prbs_order(cfg_q.len);
  assign tm   = prbs_tap(cfg_q.len);
  assign plen = cfg_q.pat_long ? 5'd20 : 5'd16;

  // bit-serial walk through the word, oldest bit first
  always_comb begin
    s_n = s_q; lock_n = lock_q; run_n = run_q; ph_n = ph_q;
    errs = '0; mis_n = 1'b0;
    b = 1'b0; e = 1'b0; ok = 1'b0; nb = 1'b0; step = 5'd1;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      b = data_i[i];
      if (cfg_q.sel == SEL_PRBS)     e = s_n[tn - 5'd1] ^ s_n[tm - 5'd1];
      else if (cfg_q.sel == SEL_CLK) e = ~s_n[0];
      else                           e = cfg_q.pat[plen - 5'd1 - ph_n];
      ok = (b == e);
      if (!ok) mis_n = 1'b1;
      if (lock_n) begin
        if (!ok) errs = errs + EW'(1);
        nb   = e;
        step = 5'd1;
      end else begin
        nb = b;
        if (ok) begin
          step = 5'd1;
          if (run_n != RUN_MAX) run_n = run_n + RUN_W'(1);
        end else begin
          step  = 5'd2;
          run_n = '0;
        end
        if (run_n == RUN_MAX) lock_n = 1'b1;
      end
      s_n  = {s_n[29:0], nb};
      ph_n = ph_n + step;
      if (ph_n >= plen) ph_n = ph_n - plen;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0; s_q <= '0; lock_q <= 1'b0; run_q <= '0; ph_q <= '0;
      irq_o <= 1'b0; mis_o <= 1'b0;
    end else if (load_i) begin
      cfg_q <= cfg_i; s_q <= '0; lock_q <= 1'b0; run_q <= '0; ph_q <= '0;
      irq_o <= 1'b0; mis_o <= 1'b0;
    end else begin
      if (chk) begin
        s_q <= s_n; lock_q <= lock_n; run_q <= run_n; ph_q <= ph_n;
      end
      irq_o <= chk && (errs != '0);
      mis_o <= chk && mis_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             flag_o <= 1'b0;
    else if (!load_i && chk && errs != '0)   flag_o <= 1'b1;
    else if (flag_clr_i)                     flag_o <= 1'b0;
  end

  assign train_o = chk && !lock_q;

  always_comb begin
    if (cfg_q.sel == SEL_PRBS || cfg_q.sel[2]) per = (32'd1 << tn) - 32'd1;
    else if (cfg_q.sel == SEL_CUST)            per = 32'(plen);
    else                                       per = '0;
  end

  pv_err_ctr #(.CNT_W(CNT_W), .INC_W(EW)) u_ctr (
    .clk_i, .rst_ni, .clr_i(cnt_clr_i), .en_i(!load_i && chk),
    .inc_i(errs), .cnt_o
  );

  pv_sync_gen #(.WORD_W(WORD_W)) u_sync (
    .clk_i, .rst_ni, .hold_i(load_i), .per_i(per), .sync_o
  );
endmodule

// File: rtl/prbs_verifier.sv
module prbs_verifier
  import pv_pkg::*;
#(
  parameter int N_LANES  = 4,
  parameter int WORD_W   = 8,
  parameter int CNT_W    = 12,
  parameter int LOCK_RUN = 40
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_LANES*WORD_W-1:0]  rx_data_i,
  input  logic [N_LANES-1:0]         load_i,
  input  logic [2:0]                 mode_i,
  input  logic [2:0]                 len_i,
  input  logic [19:0]                cpat_i,
  input  logic                       cpat_long_i,
  input  logic                       cnt_clr_i,
  input  logic [N_LANES-1:0]         flag_clr_i,
  output logic [N_LANES*CNT_W-1:0]   err_cnt_o,
  output logic [N_LANES-1:0]         irq_o,
  output logic [N_LANES-1:0]         irq_flag_o,
  output logic [N_LANES-1:0]         mismatch_o,
  output logic [N_LANES-1:0]         training_o,
  output logic [N_LANES-1:0]         sync_o
);
  logic      clr_q, clr_rise;
  lane_cfg_t cfg_in;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_q <= 1'b0;
    else         clr_q <= cnt_clr_i;
  end
  assign clr_rise = cnt_clr_i && !clr_q;

  assign cfg_in = '{sel: mode_i, len: len_i, pat: cpat_i, pat_long: cpat_long_i};

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    pv_lane #(.WORD_W(WORD_W), .CNT_W(CNT_W), .LOCK_RUN(LOCK_RUN)) u_lane (
      .clk_i, .rst_ni,
      .data_i    (rx_data_i[l*WORD_W +: WORD_W]),
      .load_i    (load_i[l]),
      .cfg_i     (cfg_in),
      .cnt_clr_i (clr_rise),
      .flag_clr_i(flag_clr_i[l]),
      .cnt_o     (err_cnt_o[l*CNT_W +: CNT_W]),
      .irq_o     (irq_o[l]),
      .flag_o    (irq_flag_o[l]),
      .mis_o     (mismatch_o[l]),
      .train_o   (training_o[l]),
      .sync_o    (sync_o[l])
    );
  end
endmodule

// File: rtl/pv_checker.sv
module pv_checker #(
  parameter int N_LANES = 4,
  parameter int CNT_W   = 12
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     cnt_clr_i,
  input logic [N_LANES-1:0]       flag_clr_i,
  input logic [N_LANES*CNT_W-1:0] err_cnt_o,
  input logic [N_LANES-1:0]       irq_o,
  input logic [N_LANES-1:0]       irq_flag_o,
  input logic [N_LANES-1:0]       mismatch_o,
  input logic [N_LANES-1:0]       training_o
);
  for (genvar l = 0; l < N_LANES; l++) begin : g_chk
    a_r7_clear_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cnt_clr_i) |=> err_cnt_o[l*CNT_W +: CNT_W] == '0);
    a_r6_no_decrease: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$rose(cnt_clr_i) |=> err_cnt_o[l*CNT_W +: CNT_W] >= $past(err_cnt_o[l*CNT_W +: CNT_W]));
    a_r9_flag_follows_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[l] |-> irq_flag_o[l]);
    a_r9_fall_needs_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_flag_o[l]) |-> $past(flag_clr_i[l]));
    a_r8_irq_implies_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[l] |-> mismatch_o[l]);
    a_r5_irq_only_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[l] |-> !training_o[l]);
  end
endmodule

bind prbs_verifier pv_checker #(.N_LANES(N_LANES), .CNT_W(CNT_W)) u_pv_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .cnt_clr_i(cnt_clr_i), .flag_clr_i(flag_clr_i),
  .err_cnt_o(err_cnt_o), .irq_o(irq_o), .irq_flag_o(irq_flag_o),
  .mismatch_o(mismatch_o), .training_o(training_o)
);

// File: tb/sim_prbs_verifier.sv
module sim_prbs_verifier;
  localparam int N = 4, W = 8, CW = 12, LOCK = 40;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [N*W-1:0]  rx_data = '0;
  logic [N-1:0]    load = '0, flag_clr = '0;
  logic [2:0]      mode = '0, len = '0;
  logic [19:0]     cpat = '0;
  logic            cpat_long = 1'b0, cnt_clr = 1'b0;
  logic [N*CW-1:0] err_cnt;
  logic [N-1:0]    irq, flag, mis, train, sync;

  prbs_verifier #(.N_LANES(N), .WORD_W(W), .CNT_W(CW), .LOCK_RUN(LOCK)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .rx_data_i(rx_data), .load_i(load), .mode_i(mode),
    .len_i(len), .cpat_i(cpat), .cpat_long_i(cpat_long), .cnt_clr_i(cnt_clr),
    .flag_clr_i(flag_clr), .err_cnt_o(err_cnt), .irq_o(irq), .irq_flag_o(flag),
    .mismatch_o(mis), .training_o(train), .sync_o(sync));

  int total = 0, bad = 0, cyc = 0;
  int sync_seen [N];

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int ord_of(int ln);
    case (ln) 0: return 7; 1: return 11; 2: return 23; 3: return 31;
      4, 5: return 15; default: return 20; endcase
  endfunction
  function automatic int tap_of(int ln);
    case (ln) 0: return 6; 1: return 9; 2: return 18; 3: return 28;
      4, 5: return 14; default: return 3; endcase
  endfunction

  // ---------------- reference model ----------------
  int m_sel[N], m_len[N], m_pat[N], m_long[N];
  longint unsigned m_hist[N];
  int m_lock[N], m_run[N], m_ph[N], m_cnt[N], m_irq[N], m_flag[N], m_mis[N], m_sync[N];
  longint m_pos[N];
  bit m_clr_prev;

  function automatic longint period_of(int l);
    if (m_sel[l] == 1 || m_sel[l] >= 4) return (longint'(1) << ord_of(m_len[l])) - 1;
    if (m_sel[l] == 3) return m_long[l] ? 20 : 16;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_clr_prev = 0;
      for (int l = 0; l < N; l++) begin
        m_sel[l] = 0; m_len[l] = 0; m_pat[l] = 0; m_long[l] = 0; m_hist[l] = 0;
        m_lock[l] = 0; m_run[l] = 0; m_ph[l] = 0; m_cnt[l] = 0; m_irq[l] = 0;
        m_flag[l] = 0; m_mis[l] = 0; m_sync[l] = 0; m_pos[l] = 0;
      end
    end else begin
      bit rise;
      rise = cnt_clr && !m_clr_prev;
      m_clr_prev = cnt_clr;
      for (int l = 0; l < N; l++) begin
        if (load[l]) begin
          m_sel[l] = mode; m_len[l] = len; m_pat[l] = cpat; m_long[l] = cpat_long;
          m_hist[l] = 0; m_lock[l] = 0; m_run[l] = 0; m_ph[l] = 0;
          m_irq[l] = 0; m_mis[l] = 0; m_pos[l] = 0; m_sync[l] = 0;
          if (rise) m_cnt[l] = 0;
          if (flag_clr[l]) m_flag[l] = 0;
        end else begin
          int errs, mm, plen, b, e, nb;
          bit checking;
          longint per;
          checking = (m_sel[l] >= 1 && m_sel[l] <= 3);
          errs = 0; mm = 0; plen = m_long[l] ? 20 : 16;
          if (checking) begin
            for (int i = W - 1; i >= 0; i--) begin
              b = rx_data[l*W + i];
              if (m_sel[l] == 1)
                e = int'(((m_hist[l] >> (ord_of(m_len[l]) - 1)) ^
                          (m_hist[l] >> (tap_of(m_len[l]) - 1))) & 1);
              else if (m_sel[l] == 2) e = int'(~m_hist[l] & 1);
              else e = (m_pat[l] >> (plen - 1 - m_ph[l])) & 1;
              if (b != e) mm = 1;
              if (m_lock[l] != 0) begin
                if (b != e) errs++;
                nb = e;
                m_ph[l] = (m_ph[l] + 1) % plen;
              end else begin
                nb = b;
                if (b == e) begin
                  if (m_run[l] < LOCK) m_run[l]++;
                  m_ph[l] = (m_ph[l] + 1) % plen;
                end else begin
                  m_run[l] = 0;
                  m_ph[l] = (m_ph[l] + 2) % plen;
                end
                if (m_run[l] == LOCK) m_lock[l] = 1;
              end
              m_hist[l] = (m_hist[l] << 1) | longint'(nb);
            end
          end
          if (rise) m_cnt[l] = 0;
          else if (checking) m_cnt[l] = (m_cnt[l] + errs > 4095) ? 4095 : m_cnt[l] + errs;
          m_irq[l] = (checking && errs > 0);
          m_mis[l] = (checking && mm != 0);
          if (m_irq[l] != 0) m_flag[l] = 1;
          else if (flag_clr[l]) m_flag[l] = 0;
          per = period_of(l);
          if (per == 0) begin m_pos[l] = 0; m_sync[l] = 0; end
          else if (m_pos[l] + W >= per) begin m_pos[l] = m_pos[l] + W - per; m_sync[l] = 1; end
          else begin m_pos[l] = m_pos[l] + W; m_sync[l] = 0; end
        end
      end
    end
  end

  // ---------------- transmit generators ----------------
  int tx_kind[N], tx_n[N], tx_m[N], tx_p[N], tx_pat[N], tx_ph[N], tx_clk[N], inv[N];
  longint unsigned tx_h[N];

  function automatic int tx_bit(int l);
    int nb;
    if (tx_kind[l] == 0) begin
      nb = int'(((tx_h[l] >> (tx_n[l] - 1)) ^ (tx_h[l] >> (tx_m[l] - 1))) & 1);
      tx_h[l] = (tx_h[l] << 1) | longint'(nb);
    end else if (tx_kind[l] == 1) begin
      tx_clk[l] = 1 - tx_clk[l];
      nb = tx_clk[l];
    end else begin
      nb = (tx_pat[l] >> (tx_p[l] - 1 - tx_ph[l])) & 1;
      tx_ph[l] = (tx_ph[l] + 1) % tx_p[l];
    end
    return nb ^ inv[l];
  endfunction

  task automatic drive_words();
    for (int l = 0; l < N; l++)
      for (int i = W - 1; i >= 0; i--) rx_data[l*W + i] = tx_bit(l)[0];
  endtask

  task automatic compare_all();
    for (int l = 0; l < N; l++) begin
      chk("R6 error count", err_cnt[l*CW +: CW], m_cnt[l]);
      chk("R8 live interrupt", irq[l], m_irq[l]);
      chk("R9 latched flag", flag[l], m_flag[l]);
      chk("R8 mismatch status", mis[l], m_mis[l]);
      chk("R5 training status", train[l], m_sel[l] >= 1 && m_sel[l] <= 3 && m_lock[l] == 0);
      chk("R10 sync pulse", sync[l], m_sync[l]);
      if (sync[l]) sync_seen[l]++;
    end
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      cyc++;
      compare_all();
      drive_words();
    end
  endtask

  // flip bits of the word already on the lane inputs
  task automatic inject(int l, logic [W-1:0] m);
    rx_data[l*W +: W] = rx_data[l*W +: W] ^ m;
  endtask

  function automatic int cnt_of(int l);
    return int'(err_cnt[l*CW +: CW]);
  endfunction

  bit done = 0;
  always @(posedge clk) begin
    if (!done && cyc > 50000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 50000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c0;
    tx_kind = '{0, 0, 1, 2};
    tx_n = '{7, 15, 0, 0}; tx_m = '{6, 14, 0, 0};
    tx_p = '{0, 0, 0, 20}; tx_pat = '{0, 0, 0, 20'h3A6F1};
    tx_ph = '{0, 0, 0, 7}; tx_clk = '{0, 0, 0, 0}; inv = '{0, 0, 0, 0};
    tx_h = '{1, 1, 0, 0};
    sync_seen = '{0, 0, 0, 0};
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // reset state
    chk("R2 reset count", err_cnt, 0);
    chk("R2 reset training", train, 0);
    chk("R2 reset flags", {irq, flag, mis, sync}, 0);
    drive_words();
    step(10);
    chk("R2 disabled lanes ignore data", err_cnt, 0);
    chk("R2 disabled lanes no training", train, 0);

    // lane 0: sequence, x^7
    mode = 3'b001; len = 3'b000; load = 4'b0001; step(2); load = '0;
    chk("R5 training after load", train[0], 1);
    // lane 1: sequence, x^15 via code 101
    mode = 3'b001; len = 3'b101; load = 4'b0010; step(1); load = '0;
    // lane 2: clock pattern
    mode = 3'b010; load = 4'b0100; step(1); load = '0;
    // lane 3: custom 20-bit
    mode = 3'b011; cpat = 20'h3A6F1; cpat_long = 1'b1; load = 4'b1000; step(1); load = '0;
    step(80);
    chk("R3 lane0 x^7 locked", train[0], 0);
    chk("R3 lane1 x^15 locked", train[1], 0);
    chk("R2 clock pattern locked", train[2], 0);
    chk("R4 custom 20-bit locked", train[3], 0);
    chk("R6 no count during training", err_cnt, 0);

    // R1: shared inputs change with load low
    mode = 3'b000; len = 3'b111; cpat = '0; cpat_long = 1'b0;
    step(20);
    chk("R1 lane0 keeps config", train[0], 0);
    inject(0, 8'h10); step(1);
    chk("R1 R6 single error counted", cnt_of(0), 1);
    chk("R8 irq after error", irq[0], 1);
    chk("R9 flag set", flag[0], 1);
    inject(0, 8'h81); step(1);
    chk("R6 two errors in one word", cnt_of(0), 3);
    flag_clr = 4'b0001; step(1); flag_clr = '0;
    chk("R9 flag cleared by write one", flag[0], 0);

    // R9: set and clear in the same clock
    inject(3, 8'h01); step(1);
    chk("R9 lane3 flag set", flag[3], 1);
    inject(3, 8'h04); flag_clr = 4'b1000; step(1); flag_clr = '0;
    chk("R9 set wins over clear", flag[3], 1);
    flag_clr = 4'b1000; step(1); flag_clr = '0;
    chk("R9 lone clear", flag[3], 0);

    // R7: clear edge coincides with an error
    inject(0, 8'h01); cnt_clr = 1'b1; step(1);
    chk("R7 clear wins over increment", cnt_of(0), 0);
    chk("R7 clear hits all lanes", cnt_of(3), 0);
    inject(0, 8'h01); step(1);
    chk("R7 held clear does not reclear", cnt_of(0), 1);
    cnt_clr = 1'b0; step(2);

    // R6: saturation with inverted stream
    inv[1] = 1; step(600); inv[1] = 0;
    chk("R6 saturates at 0xFFF", cnt_of(1), 4095);
    inject(1, 8'hFF); step(2);
    chk("R6 stays saturated", cnt_of(1), 4095);

    // R10 / R2: sync-only mode on lane 2, period 127
    c0 = cnt_of(2);
    mode = 3'b110; len = 3'b000; load = 4'b0100; step(1); load = '0;
    sync_seen[2] = 0;
    step(254);
    chk("R10 sync pulses in 2032 bits", sync_seen[2], 16);
    chk("R2 sync-only no training", train[2], 0);
    chk("R2 sync-only no counting", cnt_of(2), c0);

    // R4: custom 16-bit
    c0 = cnt_of(3);
    mode = 3'b011; cpat = 20'h3A6F1; cpat_long = 1'b0; load = 4'b1000;
    tx_p[3] = 16; tx_pat[3] = 20'h0A6F1; tx_ph[3] = 5;
    step(1); load = '0;
    step(60);
    chk("R4 custom 16-bit locked", train[3], 0);
    chk("R4 no errors after 16-bit lock", cnt_of(3), c0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule